// File: doc/BRIEF.md
# Cascaded Preset Counter with Pause (modulo 193)

This block is an 8-bit synchronous counter assembled from two identical 4-bit stages that share a single clock. The lower stage's carry-out feeds the count-enable chain of the upper stage, so the upper nibble steps only in the cycle where the lower nibble rolls over. No stage is ever clocked from a carry.

Once past its first pass, the counter cycles through 193 states. It counts from 63 up to 255, and on the next enabled edge both stages together load the word 63 (binary 0011_1111). The load takes priority over counting inside each stage. For that reason the load request comes from the top of the carry chain, which already includes the user enable. With the enable low, the count freezes at any value, 255 included.

A synchronous active-low clear puts the count at 0. From there the counter climbs through the full 0..255 range once, then stays in the 63..255 loop. The terminal flag is high while counting is enabled and the count is 255.

The count sequence is a single ring with a one-time entry path from the cleared state:
- CLEARED (0): leaves by the ENTRY transition.
- ENTRY (0..62): reached only after a clear.
- LOOP (63..254): steps up by INCREMENT.
- TERMINAL (255): goes back to 63 by RELOAD.
- HOLD: a self-transition in any state while the enable is low.

Top module: `mod193_counter`

## Requirements
- R1: When `clr_n` is 0 at a rising clock edge, the count becomes 0 after that edge, whatever `en` is.
- R2: With `clr_n`=1 and `en`=1 and a count below 255, the count rises by exactly one at each rising edge.
- R3: With `clr_n`=1 and `en`=1 and a count of 255, the next edge loads 63 (0011_1111).
- R4: With `clr_n`=1 and `en`=0, the count is unchanged across the edge at any value, including 255.
- R5: `tc` equals `en` AND (`count` == 255), combinationally.
- R6: After a clear, the count runs 0..255 once. From then on, consecutive reloads are separated by exactly 193 enabled clock edges, even when disabled cycles are interleaved.
- R7: The upper nibble `count[7:4]` changes only on an edge where the lower nibble was 15 and `en` was 1, or on a clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both stages |
| clr_n | input | 1 | Synchronous clear, active low |
| en | input | 1 | Count enable: 1 counts, 0 pauses |
| count | output | 8 | Current count value |
| tc | output | 1 | Terminal flag, enabled and count at 255 |

## Verification
A wrong carry or load decision appears at the port on the very next enabled edge. It shows as a skipped or repeated value, as an upper-nibble step in the middle of a lower cycle, or as a reload that happens while paused at 255. The scoreboard compares every edge against a model, so any such slip is reported within one cycle. A loop length error that does not disturb individual steps is caught by the spacing measurement, and it surfaces at the first reload after the first wrap.

// File: rtl/mod193_pkg.sv
package mod193_pkg;

    // Control bundle for one counter stage; clear > load > count > hold
    typedef struct packed {
        logic clear;
        logic load;
        logic enp;
        logic ent;
    } stage_ctrl_t;

endpackage

// File: rtl/cnt_stage.sv
module cnt_stage
    import mod193_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  stage_ctrl_t  ctrl,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic         rco
);

    localparam logic [W-1:0] ALL_ONES = '1;

    logic [W-1:0] q_r;
    logic [W-1:0] q_next;

    always_comb begin
        q_next = q_r;
        if (ctrl.clear) begin
            q_next = '0;
        end else if (ctrl.load) begin
            q_next = din;
        end else if (ctrl.enp && ctrl.ent) begin
            q_next = q_r + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        q_r <= q_next;
    end

    assign q   = q_r;
    // carry qualified only by the trickle enable, as in a chained stage
    assign rco = ctrl.ent && (q_r == ALL_ONES);

endmodule

// File: rtl/mod193_counter.sv
module mod193_counter
    import mod193_pkg::*;
#(
    parameter int STAGE_W    = 4,
    parameter int NUM_STAGES = 2,
    parameter int MODULUS    = 193
) (
    input  logic                          clk,
    input  logic                          clr_n,
    input  logic                          en,
    output logic [STAGE_W*NUM_STAGES-1:0] count,
    output logic                          tc
);

    localparam int CW = STAGE_W * NUM_STAGES;
    localparam logic [CW-1:0] PRESET = CW'((2 ** CW) - MODULUS);

    // carry chain: link[0] is the user enable, link[i+1] is stage i's carry
    logic [NUM_STAGES:0] link;
    logic                reload;

    assign link[0] = en;
    // top carry already includes en through the chain, so load is gated
    assign reload  = link[NUM_STAGES];

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
        stage_ctrl_t ctl;
        assign ctl.clear = !clr_n;
        assign ctl.load  = reload;
        assign ctl.enp   = en;
        assign ctl.ent   = link[g];

        cnt_stage #(.W(STAGE_W)) u_stage (
            .clk  (clk),
            .ctrl (ctl),
            .din  (PRESET[g*STAGE_W +: STAGE_W]),
            .q    (count[g*STAGE_W +: STAGE_W]),
            .rco  (link[g+1])
        );
    end

    assign tc = reload;

endmodule

// File: rtl/mod193_counter_chk.sv
module mod193_counter_chk #(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          clr_n,
    input logic          en,
    input logic [CW-1:0] count,
    input logic          tc
);

    localparam logic [CW-1:0] TOP = '1;
    localparam logic [CW-1:0] PRE = CW'(63);

    logic armed = 1'b0;
    logic live  = 1'b0;

    always_ff @(posedge clk) begin
        armed <= armed | !clr_n;
        live  <= armed | !clr_n;
    end

    // R1
    clear_zero_chk: assert property (@(posedge clk) disable iff (!armed)
        !clr_n |=> (count == '0));

    // R2
    step_up_chk: assert property (@(posedge clk) disable iff (!live || !clr_n)
        (en && count != TOP) |=> (count == $past(count) + CW'(1)));

    // R3
    reload_chk: assert property (@(posedge clk) disable iff (!live || !clr_n)
        (en && count == TOP) |=> (count == PRE));

    // R4
    pause_hold_chk: assert property (@(posedge clk) disable iff (!live || !clr_n)
        !en |=> $stable(count));

    // R5
    tc_flag_chk: assert property (@(posedge clk) disable iff (!live)
        tc == (en && count == TOP));

    // R7
    upper_step_chk: assert property (@(posedge clk) disable iff (!live || !clr_n)
        (count[CW-1:CW/2] != $past(count[CW-1:CW/2])) |->
            ($past(en) && ($past(count[CW/2-1:0]) == '1) || !$past(clr_n)));

endmodule

bind mod193_counter mod193_counter_chk #(.CW(STAGE_W*NUM_STAGES)) u_chk (
    .clk   (clk),
    .clr_n (clr_n),
    .en    (en),
    .count (count),
    .tc    (tc)
);

// File: tb/mod193_counter_bench.sv
`timescale 1ns/1ps
module mod193_counter_bench;

    logic       clk = 1'b0;
    logic       clr_n = 1'b1;
    logic       en = 1'b0;
    logic [7:0] count;
    logic       tc;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    mod193_counter u_mod193_counter (
        .clk   (clk),
        .clr_n (clr_n),
        .en    (en),
        .count (count),
        .tc    (tc)
    );

    typedef struct {
        logic [7:0] exp;
        logic       en_edge;
        logic       clr_edge;
    } item_t;

    item_t q_items[$];
    int    model = 0;

    // drive one cycle at the falling edge, check tc, queue the expected count
    task automatic step(input logic e, input logic c);
        item_t it;
        @(negedge clk);
        en    = e;
        clr_n = c;
        #0.5;
        checks++;
        if (tc !== (e && model == 255)) begin
            fails++;
            $display("FAIL R5 tc actual=%b expected=%b", tc, (e && model == 255));
        end
        if (!c) model = 0;
        else if (e) model = (model == 255) ? 63 : model + 1;
        it.exp      = 8'(model);
        it.en_edge  = e && c;
        it.clr_edge = !c;
        q_items.push_back(it);
    endtask

    // monitor: compare after every edge, measure reload spacing
    logic [7:0] prev_obs = 8'd0;
    bit   have_reload = 1'b0;
    int   en_edges = 0;

    always @(posedge clk) begin
        item_t it;
        #1;
        if (q_items.size() > 0) begin
            it = q_items.pop_front();
            checks++;
            if (count !== it.exp) begin
                fails++;
                $display("FAIL R1/R2/R3/R4 count actual=%0d expected=%0d", count, it.exp);
            end
            if (it.clr_edge) begin
                have_reload = 1'b0;
                en_edges    = 0;
            end else begin
                if (it.en_edge) en_edges++;
                if (it.en_edge && prev_obs == 8'd255 && count == 8'd63) begin
                    if (have_reload) begin
                        checks++;
                        if (en_edges != 193) begin
                            fails++;
                            $display("FAIL R6 reload spacing actual=%0d expected=193", en_edges);
                        end
                    end
                    have_reload = 1'b1;
                    en_edges    = 0;
                end
            end
            prev_obs = count;
        end
    end

    initial begin
        fork
            begin
                // R1: clear with enable both low and high
                step(1'b0, 1'b0);
                step(1'b1, 1'b0);
                // R2, R3, R6: full first pass and several loops
                for (int i = 0; i < 700; i++) step(1'b1, 1'b1);
                // R4, R5: pause at 255
                while (model != 254) step(1'b1, 1'b1);
                step(1'b1, 1'b1);
                for (int i = 0; i < 6; i++) step(1'b0, 1'b1);
                step(1'b1, 1'b1);
                // R4, R6, R7: interleaved pauses
                for (int i = 0; i < 900; i++) step((i % 3) != 1, 1'b1);
                // R1: clear mid-count while enabled, then restart
                step(1'b1, 1'b0);
                for (int i = 0; i < 300; i++) step(1'b1, 1'b1);
                @(negedge clk);
                @(negedge clk);
            end
            begin
                repeat (20000) @(posedge clk);
                fails++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule